// File: doc/BRIEF.md
# Operate Instruction Execute Unit

This unit decodes and executes the three register-to-register operate instructions of a 16-bit teaching processor: add, bitwise and, and bitwise complement. Each cycle it reads a 16-bit instruction word. It derives the two source-register read indices from that word straight away, so a register file outside the unit can return the operand values in the same cycle. When the input strobe is high, the unit computes the result. It registers the result together with the destination index and a write-enable. An output strobe marks the cycle in which those registered values are fresh.

The second operand of add and and is chosen by instruction bit 5. When bit 5 is 0 the operand is a second register. When bit 5 is 1 it is a 5-bit field sign-extended to 16 bits. Complement uses only the first source register. Any opcode outside the operate group produces no write, and the result and destination outputs keep their previous values.

A two-state controller tracks output freshness. `ST_IDLE` means no result was produced on the last edge. `ST_RESULT` means the registered outputs were loaded on the last edge. An input strobe moves or keeps the controller in `ST_RESULT` (transition *accept*). A cycle without a strobe returns it to `ST_IDLE` (transition *drain*).

Top module: `oper_exec`

## Requirements
- R1: After reset the result is 0x0000, the destination index is 0, and the write-enable and output strobe are both low.
- R2: The first source select equals instruction bits [8:6] and the second equals bits [2:0], combinationally and independent of the strobe.
- R3: With opcode bits [15:12] = 0001 and bit 5 = 0, the result is the sum of both source operands modulo 2^16.
- R4: With opcode 0001 and bit 5 = 1, the second operand is bits [4:0] sign-extended to 16 bits (for example 11110 gives 0xFFFE, so 6 plus it gives 4).
- R5: With opcode 0101, the result is the bitwise and of the first operand and the second register (bit 5 = 0) or the sign-extended immediate (bit 5 = 1).
- R6: With opcode 1001, the result is the bitwise complement of the first source operand, whatever the second operand and bits [5:0] hold.
- R7: With a strobed opcode other than 0001, 0101 or 1001, the write-enable is low in the following cycle and the result and destination outputs keep their previous values.
- R8: Result, destination (bits [11:9]) and write-enable change only in the cycle after a strobe, and the output strobe is high in exactly those cycles. Without a strobe the write-enable is low and result and destination hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| sr1_data | input | 16 | Value of the register selected by sr1_sel |
| sr2_data | input | 16 | Value of the register selected by sr2_sel |
| sr1_sel | output | 3 | First source register index |
| sr2_sel | output | 3 | Second source register index |
| res_q | output | 16 | Registered result |
| dst_q | output | 3 | Registered destination register index |
| wr_en_q | output | 1 | Registered write-enable for the destination |
| res_vld | output | 1 | Registered outputs were loaded on the last edge |

## Verification
The embedded assertions check the timing on every cycle. The output strobe follows the input strobe by one edge. A write is never reported without the strobe. Result and destination stay put when no strobe arrived or when the strobed opcode was not an operate opcode. The arithmetic itself can only be shown by the bench's scenarios, compared against a behavioural model. That includes sign extension of negative and positive immediates, wraparound of the sum, complement ignoring its low field, and the select indices.

// File: rtl/oper_pkg.sv
package oper_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_MSB = 15;
    localparam int OPC_LSB = 12;
    localparam int DST_LSB = 9;
    localparam int SRA_LSB = 6;
    localparam int SRB_LSB = 0;
    localparam int MODE_BIT = 5;
    localparam int IMM_W = 5;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        FN_NONE = 2'd0,
        FN_ADD  = 2'd1,
        FN_AND  = 2'd2,
        FN_CPL  = 2'd3
    } fn_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/oper_decode.sv
module oper_decode
    import oper_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic [INSTR_W-1:0] instr,
    output fn_e                fn,
    output logic [IDX_W-1:0]   dst_idx,
    output logic [IDX_W-1:0]   sra_idx,
    output logic [IDX_W-1:0]   srb_idx,
    output logic               use_imm,
    output logic [DATA_W-1:0]  imm_ext
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [3:0]       opc;
    logic [IMM_W-1:0] imm_raw;

    assign opc     = instr[OPC_MSB:OPC_LSB];
    assign imm_raw = instr[IMM_W-1:0];
    assign dst_idx = instr[DST_LSB +: IDX_W];
    assign sra_idx = instr[SRA_LSB +: IDX_W];
    assign srb_idx = instr[SRB_LSB +: IDX_W];
    assign use_imm = instr[MODE_BIT];
    assign imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};

    always_comb begin
        unique case (opc)
            OPC_ADD: fn = FN_ADD;
            OPC_AND: fn = FN_AND;
            OPC_NOT: fn = FN_CPL;
            default: fn = FN_NONE;
        endcase
    end
endmodule

// File: rtl/oper_alu.sv
module oper_alu
    import oper_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fn_e               fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [DATA_W-1:0] imm_b,
    input  logic              use_imm,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] opb;

    assign opb = use_imm ? imm_b : reg_b;

    always_comb begin
        unique case (fn)
            FN_ADD:  result = opa + opb;
            FN_AND:  result = opa & opb;
            FN_CPL:  result = ~opa;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/oper_exec.sv
module oper_exec
    import oper_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   sr1_data,
    input  logic [DATA_W-1:0]   sr2_data,
    output logic [IDX_W-1:0]    sr1_sel,
    output logic [IDX_W-1:0]    sr2_sel,
    output logic [DATA_W-1:0]   res_q,
    output logic [IDX_W-1:0]    dst_q,
    output logic                wr_en_q,
    output logic                res_vld
);
    fn_e               fn;
    logic [IDX_W-1:0]  dst_idx;
    logic              use_imm;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] alu_out;
    logic              is_oper;
    ctl_state_e        state_q;
    ctl_state_e        state_d;

    oper_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .instr   (instr),
        .fn      (fn),
        .dst_idx (dst_idx),
        .sra_idx (sr1_sel),
        .srb_idx (sr2_sel),
        .use_imm (use_imm),
        .imm_ext (imm_ext)
    );

    oper_alu #(.DATA_W(DATA_W)) u_alu (
        .fn      (fn),
        .opa     (sr1_data),
        .reg_b   (sr2_data),
        .imm_b   (imm_ext),
        .use_imm (use_imm),
        .result  (alu_out)
    );

    assign is_oper = (fn != FN_NONE);

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_vld ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_vld ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            dst_q   <= '0;
            wr_en_q <= 1'b0;
        end else begin
            wr_en_q <= in_vld && is_oper;
            if (in_vld && is_oper) begin
                res_q <= alu_out;
                dst_q <= dst_idx;
            end
        end
    end

    assign res_vld = (state_q == ST_RESULT);

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld);
    // R8
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !res_vld && !wr_en_q && $stable(res_q) && $stable(dst_q));
    // R7
    bad_opc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && instr[OPC_MSB:OPC_LSB] != OPC_ADD && instr[OPC_MSB:OPC_LSB] != OPC_AND
         && instr[OPC_MSB:OPC_LSB] != OPC_NOT) |=> !wr_en_q && $stable(res_q) && $stable(dst_q));
    // R8
    we_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> res_vld);
endmodule

// File: tb/oper_exec_test.sv
module oper_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] sr1_data = '0;
    logic [15:0] sr2_data = '0;
    logic [2:0]  sr1_sel, sr2_sel, dst_q;
    logic [15:0] res_q;
    logic        wr_en_q, res_vld;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_res = '0;
    logic [2:0]  m_dst = '0;
    logic        m_we = 1'b0;
    logic        m_vld = 1'b0;

    always #2.5 clk = ~clk;

    oper_exec uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .instr(instr),
        .sr1_data(sr1_data), .sr2_data(sr2_data), .sr1_sel(sr1_sel),
        .sr2_sel(sr2_sel), .res_q(res_q), .dst_q(dst_q),
        .wr_en_q(wr_en_q), .res_vld(res_vld)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(int opc, int dr, int sa, int low6);
        return 16'((opc << 12) | (dr << 9) | (sa << 6) | (low6 & 63));
    endfunction

    // Behavioural model of one edge
    task automatic model(logic v, logic [15:0] w, logic [15:0] a, logic [15:0] b);
        int opc = int'(w[15:12]);
        int imm = int'(w[4:0]);
        int opb;
        if (imm >= 16) imm = imm - 32;
        opb = w[5] ? imm : int'(b);
        m_vld = v;
        m_we = 1'b0;
        if (v && (opc == 1 || opc == 5 || opc == 9)) begin
            m_we = 1'b1;
            m_dst = w[11:9];
            if (opc == 1)      m_res = 16'((int'(a) + opb) % 65536);
            else if (opc == 5) m_res = a & 16'(opb);
            else               m_res = ~a;
        end
    endtask

    task automatic step(string tag, logic v, logic [15:0] w, logic [15:0] a, logic [15:0] b);
        @(negedge clk);
        in_vld = v; instr = w; sr1_data = a; sr2_data = b;
        #1;
        // R2 select indices
        check({tag, " R2 sr1_sel"}, 16'(sr1_sel), 16'(w[8:6]));
        check({tag, " R2 sr2_sel"}, 16'(sr2_sel), 16'(w[2:0]));
        @(posedge clk);
        model(v, w, a, b);
        @(negedge clk);
        check({tag, " R8 res_vld"}, 16'(res_vld), 16'(m_vld));
        check({tag, " wr_en"}, 16'(wr_en_q), 16'(m_we));
        check({tag, " res"}, res_q, m_res);
        check({tag, " dst"}, 16'(dst_q), 16'(m_dst));
        in_vld = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 res", res_q, 16'h0000);
        check("R1 dst", 16'(dst_q), 16'h0);
        check("R1 we", 16'(wr_en_q), 16'h0);
        check("R1 vld", 16'(res_vld), 16'h0);
        rst_n = 1'b1;
        step("R3 add reg",    1, mk(1, 3, 2, 6'b000101), 16'd3, 16'd4);
        step("R3 add wrap",   1, mk(1, 7, 7, 6'b000000), 16'hFFFF, 16'h0002);
        step("R4 add imm neg",1, mk(1, 1, 4, 6'b111110), 16'd6, 16'h1234);
        step("R4 add imm pos",1, mk(1, 5, 0, 6'b101111), 16'h7FF0, 16'h0);
        step("R8 idle hold",  0, mk(1, 2, 1, 6'b000001), 16'hAAAA, 16'h5555);
        step("R5 and reg",    1, mk(5, 6, 3, 6'b000011), 16'hF0F0, 16'h3C3C);
        step("R5 and imm pos",1, mk(5, 0, 5, 6'b101010), 16'hFFFF, 16'h0000);
        step("R5 and imm neg",1, mk(5, 4, 1, 6'b110000), 16'h1357, 16'hFFFF);
        step("R6 not",        1, mk(9, 3, 5, 6'b111111), 16'h0FF0, 16'hFFFF);
        step("R6 not lowbits",1, mk(9, 2, 6, 6'b000111), 16'h1234, 16'h9999);
        step("R7 bad opc 0",  1, 16'h0000, 16'h1111, 16'h2222);
        step("R7 bad opc F",  1, 16'hFE25, 16'h3333, 16'h4444);
        step("R7 bad opc 3",  1, mk(3, 1, 1, 6'b100001), 16'h5555, 16'h6666);
        step("R8 back2back a",1, mk(1, 1, 2, 6'b000011), 16'd10, 16'd20);
        step("R8 back2back b",1, mk(5, 2, 3, 6'b100111), 16'hFFFF, 16'd0);
        step("R8 drain",      0, 16'h0000, 16'h0, 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule